// File: doc/BRIEF.md
# CPU Bus Cycle Tracer

This block watches a 6502-style processor bus: a 16-bit address, an 8-bit data byte and a read/write flag. It takes one sample of that bus on each rising edge of the processor's PHI2 clock. PHI2 is not related to the system clock, so it passes through a synchronizer and an edge detector before use, and the bus is latched on the detected edge. The address of the latest sample is always visible on `last_addr`, whether or not a trace is running.

A pulse on `arm_start` starts a trace. From then on, each sampled bus cycle produces one event record. The record holds a sequence number counted from 1, the address, the data and the read/write flag. The trace ends in one of two ways. The first is when the processor reads the stop opcode (0xDB), which acts as a marker at the end of a test program. The second is when a cycle limit, latched at start, is reached. One clock after the final event, a done record reports why the trace ended, how many cycles it captured and the final address.

A separate enable flag gates a free-running, human-readable bus display. Starting a trace clears that flag, because the display output would collide with the traced record stream.

Top module: `cyc_tracer`

## Requirements
- R1: PHI2 passes through two synchronizing flops and an edge detector. Each low-to-high transition of PHI2 yields exactly one bus sample, however long PHI2 stays high. If PHI2 goes high before clock edge k, `last_addr` shows the bus address from clock edge k+2 onward.
- R2: `last_addr` updates on every PHI2 rising edge, including while no trace is armed. No event or done record is produced while idle.
- R3: During a trace, each sample produces a one-clock `ev_valid` pulse at clock edge k+3. The pulse carries the address, the data, `ev_rnw` (1 = read, 0 = write) and `ev_seq`. `ev_seq` is 1 for the first captured cycle and rises by 1 for each following cycle.
- R4: A read cycle (`bus_rnw`=1) whose data is 0xDB ends the trace, and that cycle is still emitted as a normal event. A write of 0xDB does not end the trace, and neither does a read of 0x00.
- R5: The trace ends when the number of captured cycles equals `limit_cfg`, which is latched when the start is accepted. A `limit_cfg` of 0 behaves as 1.
- R6: `done_valid` pulses for one clock, in the clock after the final event. `done_reason` is 1 for a stop-opcode end and 0 for a limit end. `done_count` is the number of events and `done_addr` is the final address. When the stop opcode lands on the limit cycle, the reason is 1.
- R7: An `arm_start` that arrives while `busy` is high is ignored. The running trace keeps its sequence numbering and its limit.
- R8: `mon_en` is set by `mon_on` and cleared by `mon_off`. An accepted start clears it on the next clock and overrides a `mon_on` in the same cycle. An ignored start leaves `mon_en` unchanged.
- R9: After a synchronous reset, `ev_valid`, `done_valid`, `busy` and `mon_en` are 0 and `last_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2_in | input | 1 | Processor PHI2 clock (asynchronous) |
| bus_addr | input | 16 | Processor address bus |
| bus_data | input | 8 | Processor data bus |
| bus_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| arm_start | input | 1 | Start-trace pulse |
| limit_cfg | input | 16 | Maximum cycles per trace |
| mon_on | input | 1 | Set the display enable flag |
| mon_off | input | 1 | Clear the display enable flag |
| mon_en | output | 1 | Display enable flag |
| busy | output | 1 | Trace in progress (including the done cycle) |
| last_addr | output | 16 | Address of the latest PHI2 sample |
| ev_valid | output | 1 | Event record strobe |
| ev_seq | output | 16 | Event sequence number |
| ev_addr | output | 16 | Event address |
| ev_data | output | 8 | Event data |
| ev_rnw | output | 1 | Event read/write flag |
| done_valid | output | 1 | Done record strobe |
| done_reason | output | 1 | 1 = stop opcode, 0 = limit |
| done_count | output | 16 | Captured cycle count |
| done_addr | output | 16 | Address of the final cycle |

## Verification
Two pairs of functions can fall into the same cycle. In the first, the stop-opcode detector and the limit comparator both fire on one sample. The bench provokes this with a limit of 2 and a stop-opcode read as the second cycle, and the done record must report the stop reason with a count of 2. In the second, an accepted start and a `mon_on` pulse are driven in the same clock, and `mon_en` must read 0 afterwards. A start issued during a running trace, with the flag already set, must leave the flag at 1.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_RUN  = 2'd1,
    CAP_FIN  = 2'd2
  } cap_state_t;
endpackage

// File: rtl/trc_phi2_edge.sv
module trc_phi2_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic phi2_in,
  output logic rise
);
  localparam int LAST = SYNC_STAGES - 1;

  // sync chain plus one history flop for edge detection
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], phi2_in};
  end

  assign rise = sh_q[LAST] & ~sh_q[SYNC_STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R1
endmodule

// File: rtl/trc_sampler.sv
module trc_sampler #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_rnw,
  output logic          smp_vld,
  output logic [AW-1:0] smp_addr,
  output logic [DW-1:0] smp_data,
  output logic          smp_rnw
);
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_vld  <= 1'b0;
      smp_addr <= '0;
      smp_data <= '0;
      smp_rnw  <= 1'b0;
    end else begin
      smp_vld <= rise;
      if (rise) begin
        smp_addr <= bus_addr;
        smp_data <= bus_data;
        smp_rnw  <= bus_rnw;
      end
    end
  end

  AST_SAMPLE_TRACKS: assert property (@(posedge clk) disable iff (rst)
    rise |=> (smp_addr == $past(bus_addr))); // R2
  AST_SAMPLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(smp_addr)); // R2
endmodule

// File: rtl/trc_capture.sv
module trc_capture
  import trc_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter int          CW       = 16,
  parameter logic [7:0]  STP_CODE = 8'hDB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_start,
  input  logic [CW-1:0] limit_cfg,
  input  logic          smp_vld,
  input  logic [AW-1:0] smp_addr,
  input  logic [DW-1:0] smp_data,
  input  logic          smp_rnw,
  output logic          start_ok,
  output logic          busy,
  output logic          ev_valid,
  output logic [CW-1:0] ev_seq,
  output logic [AW-1:0] ev_addr,
  output logic [DW-1:0] ev_data,
  output logic          ev_rnw,
  output logic          done_valid,
  output logic          done_reason,
  output logic [CW-1:0] done_count,
  output logic [AW-1:0] done_addr
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [DW-1:0] STP = DW'(STP_CODE);

  cap_state_t    st_q;
  logic [CW-1:0] cnt_q, lim_q, cnt_nx;
  logic          fin_stp_q, hit_stp, hit_lim;

  assign cnt_nx   = cnt_q + ONE;
  assign hit_stp  = smp_rnw && (smp_data == STP);
  assign hit_lim  = (cnt_nx >= lim_q);
  assign start_ok = arm_start && (st_q == CAP_IDLE);
  assign busy     = (st_q != CAP_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= CAP_IDLE;
      cnt_q       <= '0;
      lim_q       <= ONE;
      fin_stp_q   <= 1'b0;
      ev_valid    <= 1'b0;
      ev_seq      <= '0;
      ev_addr     <= '0;
      ev_data     <= '0;
      ev_rnw      <= 1'b0;
      done_valid  <= 1'b0;
      done_reason <= 1'b0;
      done_count  <= '0;
      done_addr   <= '0;
    end else begin
      ev_valid   <= 1'b0;
      done_valid <= 1'b0;
      unique case (st_q)
        CAP_IDLE: begin
          if (arm_start) begin
            st_q  <= CAP_RUN;
            cnt_q <= '0;
            lim_q <= (limit_cfg == '0) ? ONE : limit_cfg;
          end
        end
        CAP_RUN: begin
          if (smp_vld) begin
            ev_valid <= 1'b1;
            ev_seq   <= cnt_nx;
            ev_addr  <= smp_addr;
            ev_data  <= smp_data;
            ev_rnw   <= smp_rnw;
            cnt_q    <= cnt_nx;
            if (hit_stp || hit_lim) begin
              st_q      <= CAP_FIN;
              fin_stp_q <= hit_stp;
            end
          end
        end
        CAP_FIN: begin
          done_valid  <= 1'b1;
          done_reason <= fin_stp_q;
          done_count  <= cnt_q;
          done_addr   <= ev_addr;
          st_q        <= CAP_IDLE;
        end
        default: st_q <= CAP_IDLE;
      endcase
    end
  end

  AST_EV_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ev_valid && done_valid)); // R6
  AST_DONE_AFTER_EV: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $past(ev_valid)); // R6
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (done_count == $past(ev_seq))); // R6
  AST_STP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == CAP_RUN && smp_vld && smp_rnw && smp_data == STP) |=> (st_q == CAP_FIN)); // R4
  AST_REARM_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st_q == CAP_RUN && arm_start && !smp_vld) |=> (st_q == CAP_RUN && $stable(cnt_q))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == CAP_IDLE) |=> !ev_valid); // R2
endmodule

// File: rtl/cyc_tracer.sv
module cyc_tracer #(
  parameter int         AW          = 16,
  parameter int         DW          = 8,
  parameter int         CW          = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] STP_CODE    = 8'hDB
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phi2_in,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_rnw,
  input  logic          arm_start,
  input  logic [CW-1:0] limit_cfg,
  input  logic          mon_on,
  input  logic          mon_off,
  output logic          mon_en,
  output logic          busy,
  output logic [AW-1:0] last_addr,
  output logic          ev_valid,
  output logic [CW-1:0] ev_seq,
  output logic [AW-1:0] ev_addr,
  output logic [DW-1:0] ev_data,
  output logic          ev_rnw,
  output logic          done_valid,
  output logic          done_reason,
  output logic [CW-1:0] done_count,
  output logic [AW-1:0] done_addr
);
  logic          rise, smp_vld, smp_rnw, start_ok;
  logic [AW-1:0] smp_addr;
  logic [DW-1:0] smp_data;

  trc_phi2_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .phi2_in(phi2_in), .rise(rise)
  );

  trc_sampler #(.AW(AW), .DW(DW)) u_smp (
    .clk(clk), .rst(rst), .rise(rise),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_rnw(bus_rnw),
    .smp_vld(smp_vld), .smp_addr(smp_addr), .smp_data(smp_data), .smp_rnw(smp_rnw)
  );

  trc_capture #(.AW(AW), .DW(DW), .CW(CW), .STP_CODE(STP_CODE)) u_cap (
    .clk(clk), .rst(rst), .arm_start(arm_start), .limit_cfg(limit_cfg),
    .smp_vld(smp_vld), .smp_addr(smp_addr), .smp_data(smp_data), .smp_rnw(smp_rnw),
    .start_ok(start_ok), .busy(busy),
    .ev_valid(ev_valid), .ev_seq(ev_seq), .ev_addr(ev_addr), .ev_data(ev_data),
    .ev_rnw(ev_rnw), .done_valid(done_valid), .done_reason(done_reason),
    .done_count(done_count), .done_addr(done_addr)
  );

  assign last_addr = smp_addr;

  // accepted start has priority over a set request
  always_ff @(posedge clk) begin
    if (rst)           mon_en <= 1'b0;
    else if (start_ok) mon_en <= 1'b0;
    else if (mon_off)  mon_en <= 1'b0;
    else if (mon_on)   mon_en <= 1'b1;
  end

  AST_MON_CLEARED: assert property (@(posedge clk) disable iff (rst)
    start_ok |=> !mon_en); // R8
  AST_MON_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!start_ok && !mon_on && !mon_off) |=> $stable(mon_en)); // R8
endmodule

// File: tb/tb_cyc_tracer.sv
`timescale 1ns/1ps
module tb_cyc_tracer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phi2_in = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_rnw = 1'b1;
  logic        arm_start = 1'b0;
  logic [15:0] limit_cfg = '0;
  logic        mon_on = 1'b0, mon_off = 1'b0;
  logic        mon_en, busy, ev_valid, ev_rnw, done_valid, done_reason;
  logic [15:0] last_addr, ev_seq, ev_addr, done_count, done_addr;
  logic [7:0]  ev_data;

  int n_run = 0, n_fail = 0;
  int ev_n = 0, dn_n = 0;
  logic [15:0] e_seq [0:15];
  logic [15:0] e_addr [0:15];
  logic [7:0]  e_data [0:15];
  logic        e_rnw [0:15];
  logic        d_reason;
  logic [15:0] d_count, d_addr;

  always #2 clk = ~clk;

  cyc_tracer dut (
    .clk(clk), .rst(rst), .phi2_in(phi2_in), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rnw(bus_rnw), .arm_start(arm_start), .limit_cfg(limit_cfg), .mon_on(mon_on),
    .mon_off(mon_off), .mon_en(mon_en), .busy(busy), .last_addr(last_addr),
    .ev_valid(ev_valid), .ev_seq(ev_seq), .ev_addr(ev_addr), .ev_data(ev_data),
    .ev_rnw(ev_rnw), .done_valid(done_valid), .done_reason(done_reason),
    .done_count(done_count), .done_addr(done_addr)
  );

  // record collector, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst && ev_valid) begin
      if (ev_n < 16) begin
        e_seq[ev_n] = ev_seq; e_addr[ev_n] = ev_addr;
        e_data[ev_n] = ev_data; e_rnw[ev_n] = ev_rnw;
      end
      ev_n = ev_n + 1;
    end
    if (!rst && done_valid) begin
      d_reason = done_reason; d_count = done_count; d_addr = done_addr;
      dn_n = dn_n + 1;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic clear_log();
    ev_n = 0; dn_n = 0;
  endtask

  task automatic bus_cyc(input logic [15:0] a, input logic [7:0] d, input logic rnw);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_rnw = rnw; phi2_in = 1'b1;
    repeat (4) @(negedge clk);
    phi2_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic arm(input logic [15:0] lim);
    @(negedge clk);
    arm_start = 1'b1; limit_cfg = lim;
    @(negedge clk);
    arm_start = 1'b0;
  endtask

  task automatic t_reset();
    chk(32'(ev_valid), 0, "R9 ev_valid");
    chk(32'(done_valid), 0, "R9 done_valid");
    chk(32'(busy), 0, "R9 busy");
    chk(32'(mon_en), 0, "R9 mon_en");
    chk(32'(last_addr), 0, "R9 last_addr");
  endtask

  task automatic t_idle_addr();
    clear_log();
    @(negedge clk);
    bus_addr = 16'h1234; bus_data = 8'hDB; bus_rnw = 1'b1; phi2_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(32'(last_addr), 32'h0, "R1 last_addr not yet at edge k+1");
    @(negedge clk);
    chk(32'(last_addr), 32'h1234, "R1 last_addr at edge k+2");
    repeat (12) @(negedge clk);  // long high phase
    phi2_in = 1'b0;
    repeat (4) @(negedge clk);
    bus_cyc(16'hBEEF, 8'h00, 1'b0);
    chk(32'(last_addr), 32'hBEEF, "R2 last_addr idle update");
    chk(32'(ev_n), 0, "R2 no events while idle");
    chk(32'(dn_n), 0, "R2 no done while idle");
  endtask

  task automatic t_latency();
    clear_log();
    arm(16'd1);
    @(negedge clk);
    bus_addr = 16'h4000; bus_data = 8'h11; bus_rnw = 1'b1; phi2_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(32'(ev_valid), 0, "R3 no event before edge k+3");
    @(negedge clk);
    chk(32'(ev_valid), 1, "R3 event at edge k+3");
    chk(32'(ev_seq), 1, "R3 first seq is 1");
    phi2_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(32'(ev_n), 1, "R1 one sample for one PHI2 edge");
  endtask

  task automatic t_stp();
    clear_log();
    arm(16'd100);
    chk(32'(busy), 1, "R3 busy after start");
    bus_cyc(16'h8000, 8'h18, 1'b1);
    bus_cyc(16'h8001, 8'h00, 1'b1);  // BRK read, no stop
    bus_cyc(16'h0200, 8'hDB, 1'b0);  // write of stop value, no stop
    bus_cyc(16'h8002, 8'hA9, 1'b1);
    bus_cyc(16'h8003, 8'hDB, 1'b1);  // stop fetch
    chk(32'(ev_n), 5, "R4 events incl stop cycle");
    for (int i = 0; i < 5; i++) chk(32'(e_seq[i]), 32'(i + 1), "R3 seq order");
    chk(32'(e_addr[1]), 32'h8001, "R3 addr field");
    chk(32'(e_data[2]), 32'hDB, "R4 write of DB captured");
    chk(32'(e_rnw[2]), 0, "R3 rnw field write");
    chk(32'(e_rnw[4]), 1, "R3 rnw field read");
    chk(32'(dn_n), 1, "R6 one done record");
    chk(32'(d_reason), 1, "R6 reason stp");
    chk(32'(d_count), 5, "R6 count");
    chk(32'(d_addr), 32'h8003, "R6 final addr");
    chk(32'(busy), 0, "R4 idle after stop");
    bus_cyc(16'h8004, 8'hEA, 1'b1);
    chk(32'(ev_n), 5, "R2 no event after stop");
  endtask

  task automatic t_limit();
    clear_log();
    arm(16'd3);
    for (int i = 0; i < 5; i++) bus_cyc(16'(16'h9000 + i), 8'h55, 1'b1);
    chk(32'(ev_n), 3, "R5 limit caps events");
    chk(32'(d_reason), 0, "R6 reason limit");
    chk(32'(d_count), 3, "R6 limit count");
    chk(32'(d_addr), 32'h9002, "R6 limit final addr");
  endtask

  task automatic t_both();
    clear_log();
    arm(16'd2);
    bus_cyc(16'hA000, 8'h01, 1'b1);
    bus_cyc(16'hA001, 8'hDB, 1'b1);
    chk(32'(ev_n), 2, "R6 coincident events");
    chk(32'(d_reason), 1, "R6 stp wins over limit");
    chk(32'(d_count), 2, "R6 coincident count");
  endtask

  task automatic t_limit_zero();
    clear_log();
    arm(16'd0);
    bus_cyc(16'hB000, 8'h01, 1'b1);
    bus_cyc(16'hB001, 8'h02, 1'b1);
    chk(32'(ev_n), 1, "R5 zero limit as one");
    chk(32'(d_reason), 0, "R5 zero limit reason");
  endtask

  task automatic t_rearm();
    clear_log();
    arm(16'd3);
    @(negedge clk); mon_on = 1'b1;
    @(negedge clk); mon_on = 1'b0;
    bus_cyc(16'hC000, 8'h01, 1'b1);
    arm(16'd1);  // ignored
    chk(32'(mon_en), 1, "R8 ignored start keeps mon_en");
    bus_cyc(16'hC001, 8'h02, 1'b1);
    bus_cyc(16'hC002, 8'h03, 1'b1);
    chk(32'(ev_n), 3, "R7 limit kept after rearm");
    chk(32'(e_seq[1]), 2, "R7 seq continues");
    chk(32'(d_count), 3, "R7 done count");
  endtask

  task automatic t_monitor();
    clear_log();
    @(negedge clk); mon_off = 1'b1;
    @(negedge clk); mon_off = 1'b0;
    chk(32'(mon_en), 0, "R8 mon_off clears");
    @(negedge clk); mon_on = 1'b1;
    @(negedge clk); mon_on = 1'b0;
    chk(32'(mon_en), 1, "R8 mon_on sets");
    arm(16'd5);
    chk(32'(mon_en), 0, "R8 start clears mon_en");
    @(negedge clk); mon_on = 1'b1;
    @(negedge clk); mon_on = 1'b0;
    bus_cyc(16'hD000, 8'hDB, 1'b1);
    chk(32'(dn_n), 1, "R4 stop ends trace");
    @(negedge clk); mon_off = 1'b1;
    @(negedge clk); mon_off = 1'b0;
    @(negedge clk);
    mon_on = 1'b1; arm_start = 1'b1; limit_cfg = 16'd1;
    @(negedge clk);
    mon_on = 1'b0; arm_start = 1'b0;
    chk(32'(mon_en), 0, "R8 start beats mon_on");
    bus_cyc(16'hD100, 8'h00, 1'b1);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_addr();
    t_latency();
    t_stp();
    t_limit();
    t_both();
    t_limit_zero();
    t_rearm();
    t_monitor();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule